// File: doc/BRIEF.md
# First-Error Capture and Next-Error Accumulation Register Pair

This block logs hardware error events for later inspection by software. Each cycle it takes a vector of 32 single-cycle error pulses and records them in two sticky 32-bit registers. The first-error register holds the single error that arrived first. The next-error register collects everything that follows.

The bit positions carry fixed meanings:

- 31: fatal error from memory card B.
- 30: fatal error from memory card A.
- 29: the external system-error pin.
- 28 to 25: store-write underflow flags.
- 24: correctable memory error.
- 23: uncorrectable non-fatal error.
- 22: memory data controller fatal error.
- 21 down to 0: completion-command underflow flags.

A higher bit number takes priority when errors tie. The correctable bit is special. It may sit in the first-error register next to any other bit. When it is already set, a further correctable error is raised to the non-fatal bit.

Software reads the registers over a one-address-bit register port: select 0 is the first-error register and select 1 is the next-error register. It clears bits by writing ones. Only the power-on reset clears the contents, so the block must be kept off any warm-reset tree.

Top module: `errlog_first_capture`

## Requirements
- R1: After reset both registers read zero. The read data shows the first-error register when select is 0 and the next-error register when select is 1.
- R2: A recorded bit stays set in either register until software writes a one to it.
- R3: If the first-error register holds no bit other than bit 24, exactly one error event is captured there: the highest-numbered one. Every other event of the same cycle is OR-ed into the next-error register.
- R4: While the first-error register holds a bit other than bit 24, new error events are OR-ed into the next-error register and the first-error register gains no further bit except bit 24.
- R5: A correctable error (bit 24) with bit 24 clear sets bit 24 in the first-error register. This happens whatever other bit is there. It never lands in the next-error register and never blocks another error from being captured as first.
- R6: A correctable error that arrives while bit 24 of the first-error register is set is handled as a non-fatal event on bit 23, under R3 or R4.
- R7: A write with select 0 or 1 clears exactly the bits written as one in the selected register. Bits written as zero, and the other register, are unaffected.
- R8: The record that a correctable error has been seen is bit 24 of the first-error register. Only a write that clears that bit resets the record. Clearing other bits does not.
- R9: A clear is applied before new events in the same cycle. A bit cleared and raised in the same cycle ends set, and clearing the held first error frees the slot for an event arriving in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous assert |
| err_i | input | 32 | Per-cycle error event pulses, one per bit position |
| reg_wr_i | input | 1 | Write strobe, write-one-to-clear |
| reg_sel_i | input | 1 | Register select: 0 first-error, 1 next-error |
| reg_wdata_i | input | 32 | Clear mask for writes |
| reg_rdata_o | output | 32 | Contents of the selected register |

## Verification
The hardest states to reach are the escalation paths. These need a correctable error while bit 24 is already set, sometimes with the first slot taken by another error, and a clear that lands in the very cycle a new event arrives. The bench builds these states with short scripted sequences of pulses and clear writes, starting from a cleaned register pair. It repeats each sequence for every non-correctable bit position. It also sweeps every single event, every simultaneous pair and every ordered pair of events, so that both the priority order and the overflow into the next-error register are covered in full.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int unsigned ERR_W    = 32;
  localparam int unsigned CORR_POS = 24;
  localparam int unsigned NFAT_POS = 23;

  typedef enum logic {
    SEL_FIRST = 1'b0,
    SEL_NEXT  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/errlog_rst_sync.sv
module errlog_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/errlog_prio.sv
module errlog_prio #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] grant_o
);
  // Highest-numbered request wins.
  logic taken;

  always_comb begin
    taken   = 1'b0;
    grant_o = '0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      grant_o[i] = req_i[i] & ~taken;
      taken      = taken | req_i[i];
    end
  end
endmodule

// File: rtl/errlog_next.sv
module errlog_next #(
  parameter int unsigned W        = 32,
  parameter int unsigned CORR_POS = 24,
  parameter int unsigned NFAT_POS = 23
) (
  input  logic [W-1:0] first_q_i,
  input  logic [W-1:0] next_q_i,
  input  logic [W-1:0] err_i,
  input  logic [W-1:0] clr_first_i,
  input  logic [W-1:0] clr_next_i,
  output logic [W-1:0] first_d_o,
  output logic [W-1:0] next_d_o
);
  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] CMASK = ONE << CORR_POS;
  localparam logic [W-1:0] NMASK = ONE << NFAT_POS;

  logic [W-1:0] first_kept, next_kept, events, req, grant;
  logic         corr_hit, corr_repeat, slot_free;

  always_comb begin
    first_kept  = first_q_i & ~clr_first_i;
    next_kept   = next_q_i & ~clr_next_i;
    corr_hit    = err_i[CORR_POS];
    corr_repeat = corr_hit & first_kept[CORR_POS];
    events      = (err_i & ~CMASK) | (corr_repeat ? NMASK : '0);
    slot_free   = ~|(first_kept & ~CMASK);
    req         = slot_free ? events : '0;
  end

  errlog_prio #(.W(W)) u_prio (
    .req_i   (req),
    .grant_o (grant)
  );

  always_comb begin
    first_d_o = first_kept | grant | ((corr_hit && !corr_repeat) ? CMASK : '0);
    next_d_o  = next_kept | (events & ~grant);
  end
endmodule

// File: rtl/errlog_first_capture.sv
module errlog_first_capture
  import errlog_pkg::*;
#(
  parameter int unsigned ERR_W_P    = ERR_W,
  parameter int unsigned CORR_POS_P = CORR_POS,
  parameter int unsigned NFAT_POS_P = NFAT_POS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ERR_W_P-1:0] err_i,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [ERR_W_P-1:0] reg_wdata_i,
  output logic [ERR_W_P-1:0] reg_rdata_o
);
  localparam logic [ERR_W_P-1:0] CMASK = {{(ERR_W_P-1){1'b0}}, 1'b1} << CORR_POS_P;

  logic               rst_n;
  reg_sel_e           sel;
  logic [ERR_W_P-1:0] first_q, next_q, first_d, next_d;
  logic [ERR_W_P-1:0] clr_first, clr_next;
  logic               upd_en;

  errlog_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  always_comb begin
    sel       = reg_sel_e'(reg_sel_i);
    clr_first = (reg_wr_i && sel == SEL_FIRST) ? reg_wdata_i : '0;
    clr_next  = (reg_wr_i && sel == SEL_NEXT)  ? reg_wdata_i : '0;
    upd_en    = reg_wr_i | (|err_i);
  end

  errlog_next #(
    .W        (ERR_W_P),
    .CORR_POS (CORR_POS_P),
    .NFAT_POS (NFAT_POS_P)
  ) u_next (
    .first_q_i   (first_q),
    .next_q_i    (next_q),
    .err_i       (err_i),
    .clr_first_i (clr_first),
    .clr_next_i  (clr_next),
    .first_d_o   (first_d),
    .next_d_o    (next_d)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      next_q  <= '0;
    end else if (upd_en) begin
      first_q <= first_d;
      next_q  <= next_d;
    end
  end

  assign reg_rdata_o = (sel == SEL_FIRST) ? first_q : next_q;

  // R3
  first_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(first_q & ~CMASK));

  // R2
  first_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !reg_wr_i |=> ((first_q & $past(first_q)) == $past(first_q)));

  // R2
  next_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !reg_wr_i |=> ((next_q & $past(next_q)) == $past(next_q)));

  // R5
  corr_not_next_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !next_q[CORR_POS_P]);

  // R6
  corr_escalate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (err_i[CORR_POS_P] && first_q[CORR_POS_P] && !reg_wr_i)
      |=> (first_q[NFAT_POS_P] || next_q[NFAT_POS_P]));

  // R7
  next_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_wr_i && reg_sel_i && err_i == '0)
      |=> ((next_q & $past(reg_wdata_i)) == '0));
endmodule

// File: tb/errlog_first_capture_bench.sv
module errlog_first_capture_bench;
  localparam int C = 24;
  localparam int N = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] err = '0;
  logic        wr = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  errlog_first_capture u_errlog_first_capture (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .err_i       (err),
    .reg_wr_i    (wr),
    .reg_sel_i   (sel),
    .reg_wdata_i (wd),
    .reg_rdata_o (rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] b(input int i);
    return 32'd1 << i;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] e, input bit w, input bit s, input logic [31:0] d);
    @(negedge clk);
    err = e; wr = w; sel = s; wd = d;
    @(negedge clk);
    err = '0; wr = 1'b0; wd = '0;
  endtask

  task automatic pulse(input logic [31:0] e);
    step(e, 1'b0, 1'b0, '0);
  endtask

  task automatic clean();
    step('0, 1'b1, 1'b0, '1);
    step('0, 1'b1, 1'b1, '1);
  endtask

  task automatic expect2(input string tag, input logic [31:0] ef, input logic [31:0] en);
    sel = 1'b0; #1; chk({tag, " first"}, rdata, ef);
    sel = 1'b1; #1; chk({tag, " next"}, rdata, en);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect2("R1 reset", '0, '0);

    // R3 / R5: every single event from a clean state
    for (int i = 0; i < 32; i++) begin
      clean(); pulse(b(i));
      expect2("R3 single", b(i), '0);
    end

    // R3: simultaneous pairs, highest wins
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < i; j++) begin
        if (i == C || j == C) continue;
        clean(); pulse(b(i) | b(j));
        expect2("R3 pair", b(i), b(j));
      end
    end

    // R4 / R2: ordered pairs
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        if (i == C || j == C) continue;
        clean(); pulse(b(i)); pulse(b(j));
        expect2("R4 seq", b(i), b(j));
      end
    end

    for (int i = 0; i < 32; i++) begin
      if (i == C) continue;
      // R5: correctable bit coexists with the first error
      clean(); pulse(b(i)); pulse(b(C));
      expect2("R5 after", b(i) | b(C), '0);
      clean(); pulse(b(C)); pulse(b(i));
      expect2("R5 before", b(C) | b(i), '0);
      clean(); pulse(b(C) | b(i));
      expect2("R5 same", b(C) | b(i), '0);
      // R6: repeat correctable goes to next when slot is taken
      clean(); pulse(b(i)); pulse(b(C)); pulse(b(C));
      expect2("R6 taken", b(i) | b(C), b(N));
      // R7: selective write-one-to-clear
      begin
        int j;
        j = (i == 31) ? 30 : 31;
        clean(); pulse(b(i)); pulse(b(j));
        step('0, 1'b1, 1'b0, ~b(i));
        expect2("R7 keep", b(i), b(j));
        step('0, 1'b1, 1'b1, b(j));
        expect2("R7 clr next", b(i), '0);
        step('0, 1'b1, 1'b0, b(i));
        expect2("R7 clr first", '0, '0);
        // R9: clearing the occupant frees the slot in the same cycle
        pulse(b(i));
        step(b(j), 1'b1, 1'b0, b(i));
        expect2("R9 free", b(j), '0);
      end
      // R9: clear and raise the same bit
      clean(); pulse(b(i));
      step(b(i), 1'b1, 1'b0, b(i));
      expect2("R9 same", b(i), '0);
    end

    // R6: repeat correctable into empty slot
    clean(); pulse(b(C)); pulse(b(C));
    expect2("R6 empty", b(C) | b(N), '0);
    // R8: clearing bit 24 resets the record
    clean(); pulse(b(C)); step('0, 1'b1, 1'b0, b(C)); pulse(b(C));
    expect2("R8 reset", b(C), '0);
    // R8: clearing other bits does not
    clean(); pulse(b(C)); step('0, 1'b1, 1'b0, ~b(C)); pulse(b(C));
    expect2("R8 kept", b(C) | b(N), '0);
    // R9: bit 24 cleared and raised in the same cycle
    clean(); pulse(b(C)); step(b(C), 1'b1, 1'b0, b(C));
    expect2("R9 corr", b(C), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule